// File: doc/BRIEF.md
# Master-Clock Ratio Detector and Bit-Clock Generator

This block sits at the front of a stereo audio serial receiver. It counts master-clock cycles between consecutive rising edges of the word-select (sample) signal. It decides whether that count is one of the three legal oversampling ratios: 256, 384 or 512. A new ratio is trusted only after two periods in a row agree. Any departure from the trusted ratio withdraws the valid indication and produces a one-cycle event pulse. This includes a move to a different legal ratio, an illegal count, a stalled word select and a stopped master clock.

While the clock is valid, the block builds an internal bit clock from the master clock. The bit clock runs at 32 times the sample rate for ratios 256 and 512, and at 48 times for ratio 384. Its phase is restarted at every word-select edge, so its first rising edge lands half a bit period after that edge. A bits-per-channel indication tells the downstream shifter how many bits fit in each half of the frame. A stopped master clock cannot be seen by logic that runs on that clock. That case is therefore detected by a watchdog counter running on a separate free-running reference clock.

Top module: `mclk_ratio_gen`

## Requirements
- R1: The period is measured as the number of master-clock cycles from one word-select rising edge to the next. A count within ±2 of 256, 384 or 512 is classified as code 01, 10 or 11 on `ratio`. Any other count is illegal (code 00).
- R2: After reset or after any fault, `clk_valid` rises only when two consecutive measured periods give the same legal code. While `clk_valid` is 0, `ratio` reads 00 and `word_bits` reads 0.
- R3: While valid, a measured period with a different legal code drops `clk_valid`. The new ratio is accepted after one more period with the same code.
- R4: While valid, an illegal measured period drops `clk_valid`. The block stays invalid for as long as periods remain illegal.
- R5: While valid, if no word-select rising edge arrives for more than 514 master-clock cycles, `clk_valid` drops.
- R6: If the master clock stops, `clk_valid` falls to 0 within TIMEOUT_REF plus a few reference-clock cycles. After the master clock restarts with a legal ratio, the block reacquires.
- R7: The bit clock divides the master clock by 8 for ratios 256 and 384, and by 16 for ratio 512. This gives 32, 48 and 32 bit-clock rising edges per word-select period.
- R8: After each word-select edge (rising or falling), the bit clock is low and first rises half a bit period later: 4 master-clock cycles for ratios 256 and 384, 8 for ratio 512. The bit clock stays low while the block is not valid.
- R9: `word_bits` reads 16 for ratios 256 and 512, and 24 for ratio 384.
- R10: `clk_event` is a single-cycle pulse each time validity is lost in the master-clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all detection and bit-clock logic runs on its rising edge |
| ref_clk | input | 1 | Free-running reference clock for the master-clock watchdog |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| ws | input | 1 | Word select, synchronous to mclk; one period is one stereo sample |
| ratio | output | 2 | Detected ratio: 00 invalid, 01 = 256, 10 = 384, 11 = 512 |
| clk_valid | output | 1 | High while a legal, confirmed ratio is present and mclk is running |
| clk_event | output | 1 | One-cycle pulse when validity is lost |
| bclk | output | 1 | Internal bit clock derived from mclk |
| word_bits | output | 5 | Bits per channel slot: 16, 24, or 0 when invalid |

## Verification
Directed word-select waveforms at each legal ratio check that the block classifies all three ratios and selects the matching divide. They also check that the number of bit-clock edges and the delay to the first edge after a frame edge follow the ratio. Periods just inside the ±2 window (254, 258) and just outside it (259), plus a clearly illegal 300, separate the tolerance rule from the legal-code test. Switching between two legal ratios shows that the block faults on a legal change and re-accepts only after a second agreeing period. A held word-select line is distinguished from a halted master clock: the first is caught by the in-domain counter and the second only by the reference-clock watchdog.

// File: rtl/mclk_ratio_gen.sv
`timescale 1ns/1ps
module mclk_ratio_gen #(
  parameter int TOL         = 2,
  parameter int CNT_W       = 10,
  parameter int TIMEOUT_REF = 1024
) (
  input  logic       mclk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       ws,
  output logic [1:0] ratio,
  output logic       clk_valid,
  output logic       clk_event,
  output logic       bclk,
  output logic [4:0] word_bits
);
  localparam int R_LO      = 256;
  localparam int R_MID     = 384;
  localparam int R_HI      = 512;
  localparam int DIV_LO    = R_LO / 32;
  localparam int DIV_MID   = R_MID / 48;
  localparam int DIV_HI    = R_HI / 32;
  localparam int PH_W      = $clog2(DIV_HI);
  localparam int STALL_LIM = R_HI + TOL;
  localparam int TO_W      = $clog2(TIMEOUT_REF + 1);

  logic             ws_q, valid_q, armed, event_q, bclk_q, tog;
  logic             loss_m1, loss_m2, loss_ref;
  logic [1:0]       cand, ratio_q, meas;
  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  ph, ph_last, ph_half, ph_nx;
  logic             r_s1, r_s2, r_s3;
  logic [TO_W-1:0]  tcnt;

  wire ws_rise = ws & ~ws_q;
  wire ws_edge = ws ^ ws_q;

  function automatic logic [1:0] classify(input logic [CNT_W-1:0] c);
    int v;
    v = int'(c);
    if (v >= R_LO - TOL && v <= R_LO + TOL)   return 2'b01;
    if (v >= R_MID - TOL && v <= R_MID + TOL) return 2'b10;
    if (v >= R_HI - TOL && v <= R_HI + TOL)   return 2'b11;
    return 2'b00;
  endfunction

  assign meas = classify(cnt);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q    <= 1'b0;
      cnt     <= '0;
      tog     <= 1'b0;
      armed   <= 1'b0;
      cand    <= 2'b00;
      ratio_q <= 2'b00;
      valid_q <= 1'b0;
      event_q <= 1'b0;
      loss_m1 <= 1'b0;
      loss_m2 <= 1'b0;
    end else begin
      ws_q    <= ws;
      event_q <= 1'b0;
      loss_m1 <= loss_ref;
      loss_m2 <= loss_m1;
      if (ws_rise)    cnt <= CNT_W'(1);
      else if (~&cnt) cnt <= cnt + 1'b1;
      if (ws_rise) tog <= ~tog;
      if (loss_m2) begin
        armed   <= 1'b0;
        cand    <= 2'b00;
        ratio_q <= 2'b00;
        if (valid_q) begin
          valid_q <= 1'b0;
          event_q <= 1'b1;
        end
      end else if (ws_rise) begin
        armed <= 1'b1;
        if (armed) begin
          if (valid_q) begin
            if (meas != ratio_q) begin
              valid_q <= 1'b0;
              event_q <= 1'b1;
              ratio_q <= 2'b00;
              cand    <= meas;
            end
          end else if (meas != 2'b00 && meas == cand) begin
            valid_q <= 1'b1;
            ratio_q <= meas;
          end else begin
            cand <= meas;
          end
        end
      end else if (valid_q && cnt > CNT_W'(STALL_LIM)) begin
        valid_q <= 1'b0;
        event_q <= 1'b1;
        ratio_q <= 2'b00;
        cand    <= 2'b00;
      end
    end
  end

  always_comb begin
    case (ratio_q)
      2'b11:   ph_last = PH_W'(DIV_HI - 1);
      2'b10:   ph_last = PH_W'(DIV_MID - 1);
      default: ph_last = PH_W'(DIV_LO - 1);
    endcase
    ph_half = PH_W'((int'(ph_last) + 1) / 2);
    ph_nx   = (ph == ph_last) ? '0 : ph + 1'b1;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      bclk_q <= 1'b0;
    end else if (ws_edge || !valid_q) begin
      ph     <= '0;
      bclk_q <= 1'b0;
    end else begin
      ph     <= ph_nx;
      bclk_q <= (ph_nx >= ph_half);
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1     <= 1'b0;
      r_s2     <= 1'b0;
      r_s3     <= 1'b0;
      tcnt     <= '0;
      loss_ref <= 1'b0;
    end else begin
      r_s1 <= tog;
      r_s2 <= r_s1;
      r_s3 <= r_s2;
      if (r_s2 != r_s3)                     tcnt <= '0;
      else if (tcnt != TO_W'(TIMEOUT_REF))  tcnt <= tcnt + 1'b1;
      loss_ref <= (tcnt == TO_W'(TIMEOUT_REF));
    end
  end

  assign clk_valid = valid_q & ~loss_ref;
  assign ratio     = clk_valid ? ratio_q : 2'b00;
  assign word_bits = !clk_valid ? 5'd0 : (ratio_q == 2'b10) ? 5'd24 : 5'd16;
  assign clk_event = event_q;
  assign bclk      = bclk_q;
endmodule

module mclk_ratio_gen_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic       ws,
  input logic       ws_q,
  input logic       valid_q,
  input logic [1:0] ratio_q,
  input logic       clk_event,
  input logic       bclk
);
  a_r10_event_on_drop: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(valid_q) |-> clk_event);
  a_r10_event_single: assert property (@(posedge mclk) disable iff (!rst_n)
    clk_event |=> !clk_event);
  a_r8_bclk_idle: assert property (@(posedge mclk) disable iff (!rst_n)
    !valid_q |=> !bclk);
  a_r8_edge_low: assert property (@(posedge mclk) disable iff (!rst_n)
    (ws != ws_q) |=> !bclk);
  a_r2_ratio_legal: assert property (@(posedge mclk) disable iff (!rst_n)
    valid_q |-> ratio_q != 2'b00);
endmodule

bind mclk_ratio_gen mclk_ratio_gen_chk chk (
  .mclk(mclk), .rst_n(rst_n), .ws(ws), .ws_q(ws_q), .valid_q(valid_q),
  .ratio_q(ratio_q), .clk_event(clk_event), .bclk(bclk)
);

// File: tb/mclk_ratio_gen_test.sv
`timescale 1ns/1ps
module mclk_ratio_gen_test;
  localparam int TIMEOUT_REF = 1024;
  logic mclk_raw = 1'b0, mclk_run = 1'b1, ref_clk = 1'b0, rst_n = 1'b0, ws = 1'b0;
  logic mclk;
  logic [1:0] ratio;
  logic clk_valid, clk_event, bclk;
  logic [4:0] word_bits;
  int tests = 0, fails = 0, ev_cnt = 0, rises = 0, first_rise = -1;
  logic last_bclk = 1'b0;

  assign mclk = mclk_raw & mclk_run;
  always #10 mclk_raw = ~mclk_raw;
  always #18.5 ref_clk = ~ref_clk;

  mclk_ratio_gen #(.TOL(2), .CNT_W(10), .TIMEOUT_REF(TIMEOUT_REF)) uut (
    .mclk(mclk), .ref_clk(ref_clk), .rst_n(rst_n), .ws(ws), .ratio(ratio),
    .clk_valid(clk_valid), .clk_event(clk_event), .bclk(bclk), .word_bits(word_bits));

  always @(negedge mclk_raw) if (rst_n && clk_event) ev_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int r, input int n);
    for (int p = 0; p < n; p++) begin
      first_rise = -1;
      for (int i = 0; i < r; i++) begin
        @(negedge mclk_raw);
        if (bclk && !last_bclk) rises++;
        if (bclk && i > 0 && first_rise < 0) first_rise = i;
        last_bclk = bclk;
        ws = (i < (r + 1) / 2);
      end
    end
  endtask

  task automatic hold_low(input int n);
    repeat (n) begin
      @(negedge mclk_raw);
      last_bclk = bclk;
      ws = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge mclk_raw);
    chk("R2 reset clk_valid", clk_valid, 0);
    chk("R2 reset ratio", ratio, 0);
    chk("R8 reset bclk", bclk, 0);
    chk("R2 reset word_bits", word_bits, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_acquire_256;
    drive(256, 2);
    chk("R2 one period not enough", clk_valid, 0);
    drive(256, 1);
    chk("R2 valid after two matches", clk_valid, 1);
    chk("R1 ratio code 256", ratio, 1);
    chk("R9 word_bits 256", word_bits, 16);
    rises = 0;
    drive(256, 1);
    chk("R7 rises per period 256", rises, 32);
    chk("R8 first rise delay 256", first_rise, 5);
  endtask

  task automatic t_change_384;
    int ev0 = ev_cnt;
    drive(384, 2);
    chk("R3 legal change drops valid", clk_valid, 0);
    chk("R3 ratio reads 00", ratio, 0);
    chk("R10 one event on change", ev_cnt - ev0, 1);
    chk("R8 bclk low when invalid", bclk, 0);
    drive(384, 1);
    chk("R3 reacquire 384", clk_valid, 1);
    chk("R1 ratio code 384", ratio, 2);
    chk("R9 word_bits 384", word_bits, 24);
    rises = 0;
    drive(384, 1);
    chk("R7 rises per period 384", rises, 48);
    chk("R8 first rise delay 384", first_rise, 5);
  endtask

  task automatic t_512;
    drive(512, 2);
    chk("R3 change to 512 drops valid", clk_valid, 0);
    drive(512, 1);
    chk("R1 ratio code 512", ratio, 3);
    chk("R9 word_bits 512", word_bits, 16);
    rises = 0;
    drive(512, 1);
    chk("R7 rises per period 512", rises, 32);
    chk("R8 first rise delay 512", first_rise, 9);
  endtask

  task automatic t_tolerance;
    int ev0;
    drive(258, 3);
    chk("R1 258 accepted as 256", ratio, 1);
    ev0 = ev_cnt;
    drive(254, 2);
    chk("R1 254 keeps 256 valid", clk_valid, 1);
    chk("R1 no event inside window", ev_cnt - ev0, 0);
    drive(259, 2);
    chk("R4 259 outside window invalid", clk_valid, 0);
    chk("R10 event on 259", ev_cnt - ev0, 1);
    drive(259, 2);
    chk("R4 stays invalid on 259", ratio, 0);
  endtask

  task automatic t_illegal;
    int ev0;
    drive(256, 3);
    chk("R2 reacquire after illegal", clk_valid, 1);
    ev0 = ev_cnt;
    drive(300, 2);
    chk("R4 300 drops valid", clk_valid, 0);
    drive(300, 3);
    chk("R4 300 stays invalid", clk_valid, 0);
    chk("R10 single event for illegal run", ev_cnt - ev0, 1);
  endtask

  task automatic t_stall;
    int ev0;
    drive(512, 3);
    chk("R2 valid before stall", clk_valid, 1);
    ev0 = ev_cnt;
    hold_low(600);
    chk("R5 stall drops valid", clk_valid, 0);
    chk("R10 event on stall", ev_cnt - ev0, 1);
  endtask

  task automatic t_mclk_stop;
    int ev0;
    drive(256, 3);
    chk("R6 valid before stop", clk_valid, 1);
    ev0 = ev_cnt;
    @(negedge mclk_raw);
    mclk_run = 1'b0;
    #((TIMEOUT_REF + 10) * 37);
    chk("R6 clk_valid low with mclk stopped", clk_valid, 0);
    chk("R6 ratio 00 with mclk stopped", ratio, 0);
    @(negedge mclk_raw);
    mclk_run = 1'b1;
    drive(256, 6);
    chk("R6 reacquire after restart", clk_valid, 1);
    chk("R6 ratio after restart", ratio, 1);
    chk("R10 event after restart", ev_cnt - ev0, 1);
  endtask

  initial begin
    #3_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire_256();
    t_change_384();
    t_512();
    t_tolerance();
    t_illegal();
    t_stall();
    t_mclk_stop();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule